// File: doc/BRIEF.md
# Virtual Output Queue Crossbar Switch

This block is a small packet switch with `N_PORTS` inputs and `N_PORTS` outputs (four of each by default). Each input splits its storage into one queue per output. An arriving frame carries a destination tag on its input port, and it is written only into the queue that the input keeps for that output. Because of this, a frame headed for a stalled output cannot hold back frames from the same input that are headed elsewhere.

In every cycle a single-pass request/grant/accept scheduler builds a conflict-free match between inputs and outputs. Each output grants one requesting input through its own rotating pointer. Each input then accepts one of the grants it received through a second rotating pointer. Both pointers advance only on an accepted match. The matched queue heads pass through an AND-OR crossbar straight to the outputs, and the queue is popped in the same cycle. The output side holds no storage. Frames are single-beat words of `WIDTH` bits that the switch carries through unchanged.

No state machine is needed. The only sequential state is the queue pointers and the two sets of rotating pointers.

Top module: `voq_switch`

## Requirements
- R1: After reset every queue is empty. `out_valid` is all zeros, and `in_ready` is all ones whatever value `in_dest` holds.
- R2: A frame accepted on input i (`in_valid[i]` and `in_ready[i]` high at a clock edge) is stored only in the queue of input i for output `in_dest[i]`. It later appears, unchanged, only on that output. `in_ready[i]` is low exactly when that queue already holds `DEPTH` (default 4) frames. A frame popped in the same cycle does not free a slot until the next cycle.
- R3: A frame for a ready output leaves even while frames from the same input wait for a stalled output. If the frame is the only request for that output, it appears on `out_valid` in the cycle after the edge that accepted it.
- R4: In any cycle each input delivers at most one frame and each output carries at most one frame.
- R5: `out_valid[j]` is asserted only in cycles when `out_ready[j]` is high. Every asserted `out_valid` completes a transfer in that cycle.
- R6: Frames from one input to one output leave in the order in which they were accepted.
- R7: Every accepted frame is delivered exactly once. No frame is lost and none is duplicated.
- R8: When all inputs send continuously to one output that stays ready, an input with a queued frame for that output waits at most `N_PORTS`-1 cycles before it is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N_PORTS | Frame present on input i |
| in_ready | output | N_PORTS | Input i can accept a frame for its current `in_dest` |
| in_data | input | N_PORTS*WIDTH | Frame word of input i at bits [i*WIDTH +: WIDTH] |
| in_dest | input | N_PORTS*clog2(N_PORTS) | Destination output index of input i |
| out_valid | output | N_PORTS | Frame presented on output j |
| out_ready | input | N_PORTS | Output j can take a frame this cycle |
| out_data | output | N_PORTS*WIDTH | Frame word of output j at bits [j*WIDTH +: WIDTH] |

## Verification
The bench drives five traffic patterns:
- **Directed isolation case.** One input fills its queue for a stalled output and then sends to a free output. This separates per-output queuing from a single shared queue, and it exposes an off-by-one in the full threshold.
- **Uniform spread.** Destinations are spread pseudo-randomly with all outputs ready, which exercises matching under heavy contention.
- **Fixed permutation.** This gives a contention-free baseline.
- **Hotspot.** All inputs send to one output, which measures the wait bound of the rotating pointers.
- **Random backpressure.** Destinations are random and output ready is withdrawn at random, which stresses the full threshold and the rule that valid follows ready.

Each frame word encodes its source, destination and a per-pair sequence number, so a bench model can prove order, routing and completeness.

// File: rtl/voq_pkg.sv
package voq_pkg;
    localparam int DEF_PORTS = 4;
    localparam int DEF_DEPTH = 4;
    localparam int DEF_WIDTH = 16;

    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/voq_fifo.sv
module voq_fifo #(
    parameter int WIDTH = voq_pkg::DEF_WIDTH,
    parameter int DEPTH = voq_pkg::DEF_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = voq_pkg::idx_bits(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wr_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr[AW-1:0]] <= din;
    end

    always_comb begin
        dout  = mem[rd_ptr[AW-1:0]];
        empty = (wr_ptr == rd_ptr);
        full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    end

    // R2: the input side never writes into a queue that is already full
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R7: the scheduler never drains a queue that is empty
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/voq_rr_arbiter.sv
module voq_rr_arbiter #(
    parameter int N = voq_pkg::DEF_PORTS,
    localparam int IW = voq_pkg::idx_bits(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic [N-1:0]  gnt
);
    logic          found;
    logic [IW-1:0] idx;

    always_comb begin
        gnt   = '0;
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            idx = IW'((int'(ptr) + k) % N);
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/voq_scheduler.sv
module voq_scheduler #(
    parameter int N = voq_pkg::DEF_PORTS,
    localparam int IW = voq_pkg::idx_bits(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N*N-1:0] req,
    input  logic [N-1:0]   out_ready,
    output logic [N*N-1:0] match
);
    logic [IW-1:0] grant_ptr  [N];
    logic [IW-1:0] accept_ptr [N];
    logic [N-1:0]  col_req    [N];
    logic [N-1:0]  col_gnt    [N];
    logic [N-1:0]  row_gnt    [N];
    logic [N-1:0]  row_acc    [N];
    logic [N-1:0]  col_match  [N];

    always_comb begin
        for (int j = 0; j < N; j++)
            for (int i = 0; i < N; i++)
                col_req[j][i] = req[i*N+j] && out_ready[j];
    end

    for (genvar j = 0; j < N; j++) begin : g_grant
        voq_rr_arbiter #(.N(N)) u_grant (
            .req(col_req[j]), .ptr(grant_ptr[j]), .gnt(col_gnt[j]));
    end

    always_comb begin
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                row_gnt[i][j] = col_gnt[j][i];
    end

    for (genvar i = 0; i < N; i++) begin : g_accept
        voq_rr_arbiter #(.N(N)) u_accept (
            .req(row_gnt[i]), .ptr(accept_ptr[i]), .gnt(row_acc[i]));
    end

    always_comb begin
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                match[i*N+j]    = row_acc[i][j];
                col_match[j][i] = row_acc[i][j];
            end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) begin
                grant_ptr[k]  <= '0;
                accept_ptr[k] <= '0;
            end
        end else begin
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++)
                    if (row_acc[i][j]) begin
                        grant_ptr[j]  <= IW'((i + 1) % N);
                        accept_ptr[i] <= IW'((j + 1) % N);
                    end
        end
    end

    for (genvar k = 0; k < N; k++) begin : g_chk
        // R4: one frame per input per cycle
        a_r4_input_single: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(row_acc[k]));
        // R4: one frame per output per cycle
        a_r4_output_single: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col_match[k]));
        // R5: no match towards an output that is not ready
        a_r5_match_ready: assert property (@(posedge clk) disable iff (!rst_n)
            (|col_match[k]) |-> out_ready[k]);
    end
endmodule

// File: rtl/voq_switch.sv
module voq_switch #(
    parameter int N_PORTS = voq_pkg::DEF_PORTS,
    parameter int DEPTH   = voq_pkg::DEF_DEPTH,
    parameter int WIDTH   = voq_pkg::DEF_WIDTH,
    localparam int IW     = voq_pkg::idx_bits(N_PORTS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_PORTS-1:0]       in_valid,
    output logic [N_PORTS-1:0]       in_ready,
    input  logic [N_PORTS*WIDTH-1:0] in_data,
    input  logic [N_PORTS*IW-1:0]    in_dest,
    output logic [N_PORTS-1:0]       out_valid,
    input  logic [N_PORTS-1:0]       out_ready,
    output logic [N_PORTS*WIDTH-1:0] out_data
);
    localparam int NQ = N_PORTS * N_PORTS;

    logic [NQ-1:0]    q_push, q_pop, q_empty, q_full;
    logic [WIDTH-1:0] q_head [NQ];

    for (genvar i = 0; i < N_PORTS; i++) begin : g_in
        for (genvar j = 0; j < N_PORTS; j++) begin : g_out
            assign q_push[i*N_PORTS+j] = in_valid[i] && in_ready[i] &&
                                         (in_dest[i*IW +: IW] == IW'(j));
            voq_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_q (
                .clk  (clk),
                .rst_n(rst_n),
                .push (q_push[i*N_PORTS+j]),
                .din  (in_data[i*WIDTH +: WIDTH]),
                .pop  (q_pop[i*N_PORTS+j]),
                .dout (q_head[i*N_PORTS+j]),
                .empty(q_empty[i*N_PORTS+j]),
                .full (q_full[i*N_PORTS+j])
            );
            // R2: an accepted frame is present in its queue on the next cycle
            a_r2_push_lands: assert property (@(posedge clk) disable iff (!rst_n)
                q_push[i*N_PORTS+j] |=> !q_empty[i*N_PORTS+j]);
        end
    end

    always_comb begin
        for (int i = 0; i < N_PORTS; i++) begin
            in_ready[i] = 1'b0;
            for (int j = 0; j < N_PORTS; j++)
                if (in_dest[i*IW +: IW] == IW'(j))
                    in_ready[i] = !q_full[i*N_PORTS+j];
        end
    end

    voq_scheduler #(.N(N_PORTS)) u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (~q_empty),
        .out_ready(out_ready),
        .match    (q_pop)
    );

    always_comb begin
        for (int j = 0; j < N_PORTS; j++) begin
            out_valid[j]             = 1'b0;
            out_data[j*WIDTH +: WIDTH] = '0;
            for (int i = 0; i < N_PORTS; i++)
                if (q_pop[i*N_PORTS+j]) begin
                    out_valid[j]               = 1'b1;
                    out_data[j*WIDTH +: WIDTH] = out_data[j*WIDTH +: WIDTH] | q_head[i*N_PORTS+j];
                end
        end
    end

    // R5: valid follows ready on every output
    a_r5_valid_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid & ~out_ready) == '0);
    // R1: the cycle after reset nothing is presented
    a_r1_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> (out_valid == '0));
endmodule

// File: tb/voq_switch_test.sv
module voq_switch_test;
    localparam int N  = 4;
    localparam int D  = 4;
    localparam int W  = 16;
    localparam int IW = 2;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [N-1:0]     in_valid, in_ready, out_valid, out_ready;
    logic [N*W-1:0]   in_data, out_data;
    logic [N*IW-1:0]  in_dest;

    voq_switch #(.N_PORTS(N), .DEPTH(D), .WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_dest(in_dest), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data));

    always #2 clk = ~clk;

    int n_chk = 0, n_err = 0;
    int push_seq [N][N];
    int pop_seq  [N][N];
    logic [N-1:0]    want;
    logic [IW-1:0]   want_dest [N];
    logic [N-1:0]    ordy;
    logic [N-1:0]    seen_valid;
    int  cyc = 0;
    bit  hot_phase = 0;
    int  wait_cnt [N];
    int  max_wait = 0;
    bit  finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic step();
        int src_cnt [N];
        bit served0 [N];
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            in_valid[i]          = want[i];
            in_dest[i*IW +: IW]  = want_dest[i];
            in_data[i*W +: W]    = {2'(i), want_dest[i], 12'(push_seq[i][want_dest[i]])};
            src_cnt[i] = 0;
            served0[i] = 0;
        end
        out_ready = ordy;
        #1;
        for (int i = 0; i < N; i++)
            if (in_valid[i]) begin
                int occ;
                occ = push_seq[i][want_dest[i]] - pop_seq[i][want_dest[i]];
                chk(in_ready[i] == (occ < D), "R2 ready", int'(in_ready[i]), int'(occ < D));
            end
        seen_valid = out_valid;
        for (int j = 0; j < N; j++) begin
            if (out_valid[j] && !out_ready[j])
                chk(0, "R5 valid without ready", 1, 0);
            if (out_valid[j] && out_ready[j]) begin
                int s, d, q;
                s = int'(out_data[j*W+14 +: 2]);
                d = int'(out_data[j*W+12 +: 2]);
                q = int'(out_data[j*W +: 12]);
                chk(d == j, "R2 routing", d, j);
                chk(q == pop_seq[s][j] && pop_seq[s][j] < push_seq[s][j], "R6 order", q, pop_seq[s][j]);
                pop_seq[s][j]++;
                src_cnt[s]++;
                if (j == 0) served0[s] = 1;
            end
        end
        for (int i = 0; i < N; i++)
            if (src_cnt[i] > 1) chk(0, "R4 input single", src_cnt[i], 1);
        if (hot_phase)
            for (int i = 0; i < N; i++) begin
                if (push_seq[i][0] - pop_seq[i][0] + (served0[i] ? 1 : 0) > 0 && !served0[i])
                    wait_cnt[i]++;
                else
                    wait_cnt[i] = 0;
                if (wait_cnt[i] > max_wait) max_wait = wait_cnt[i];
            end
        for (int i = 0; i < N; i++)
            if (in_valid[i] && in_ready[i]) push_seq[i][want_dest[i]]++;
        cyc++;
    endtask

    initial begin
        rst_n = 1'b0; in_valid = '0; in_data = '0; in_dest = '0; out_ready = '0;
        want = '0; ordy = '0;
        for (int i = 0; i < N; i++) begin
            want_dest[i] = '0; wait_cnt[i] = 0;
            for (int j = 0; j < N; j++) begin push_seq[i][j] = 0; pop_seq[i][j] = 0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: idle outputs, all inputs ready, for every destination value
        chk(out_valid == '0, "R1 out_valid", int'(out_valid), 0);
        for (int d = 0; d < N; d++) begin
            in_dest = {N{IW'(d)}};
            #1;
            chk(in_ready == '1, "R1 in_ready", int'(in_ready), 15);
        end

        // Directed: fill input 0 queue for stalled output 0
        ordy = '0;
        want = 4'b0001; want_dest[0] = 0;
        repeat (D) step();
        step();
        chk(in_ready[0] == 1'b0, "R2 full threshold", int'(in_ready[0]), 0);
        chk(push_seq[0][0] == D, "R2 accepted count", push_seq[0][0], D);
        // R3: frame for free output 1 overtakes the blocked frames
        ordy = 4'b0010; want_dest[0] = 1;
        step();
        want = '0;
        step();
        chk(seen_valid == 4'b0010, "R3 no head-of-line blocking", int'(seen_valid), 2);
        chk(pop_seq[0][1] == 1, "R3 delivered count", pop_seq[0][1], 1);
        chk(pop_seq[0][0] == 0, "R3 blocked output held", pop_seq[0][0], 0);
        ordy = '1;
        repeat (10) step();
        chk(pop_seq[0][0] == D, "R7 drained after release", pop_seq[0][0], D);

        // Uniform spread
        want = '1;
        for (int c = 0; c < 400; c++) begin
            for (int i = 0; i < N; i++)
                want_dest[i] = IW'((i*7 + c*13 + (c>>2)*5 + (c*c) % 11) % N);
            step();
        end
        // Permutation
        for (int i = 0; i < N; i++) want_dest[i] = IW'((i + 1) % N);
        repeat (50) step();
        chk(seen_valid == '1, "R4 permutation full rate", int'(seen_valid), 15);

        // Hotspot on output 0 (R8)
        for (int i = 0; i < N; i++) begin want_dest[i] = 0; wait_cnt[i] = 0; end
        hot_phase = 1;
        repeat (200) step();
        hot_phase = 0;
        chk(max_wait <= N - 1, "R8 round-robin wait", max_wait, N - 1);

        // Random backpressure
        for (int c = 0; c < 600; c++) begin
            for (int i = 0; i < N; i++)
                want_dest[i] = IW'((i*5 + c*3 + (c/7) + (c*c) % 13) % N);
            for (int j = 0; j < N; j++)
                ordy[j] = ((c*5 + j*3 + c/3 + (c*j) % 7) % 4) != 0;
            want = 4'(((c*11) % 16) | 1);
            step();
        end

        // Drain and account (R7)
        want = '0; ordy = '1;
        repeat (60) step();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                chk(pop_seq[i][j] == push_seq[i][j], "R7 no loss", pop_seq[i][j], push_seq[i][j]);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule